// File: doc/BRIEF.md
# Instrument Status Reporting Unit

This block keeps the status registers of a remotely controlled instrument. The instrument core sends single-cycle event pulses. Each pulse latches a bit in an 8-bit event register, and the bit stays set until software reads the register. An event mask selects which latched bits count toward an event summary bit. The core pushes reply bytes into a 16-entry first-in first-out message queue, and while that queue holds data a message-available bit is raised.

The two summary bits form a status byte. A service-request mask selects which status bits may request service. When the masked status first becomes non-zero, a request-for-service flag is set in the status byte and drives the `srq` line. A register port handles all software access: it reads and clears events, reads and writes both masks, performs a serial poll, clears status and pops the queue. Results come back one cycle after the request.

Top module: `status_report_unit`

## Requirements
- R1: While `rst` is high, and after it falls, the event register, both masks, the queue and the request flag are all zero. `status_byte`, `srq`, `rd_valid` and `rd_data` read 0.
- R2: A 1 on `evt_pulse[i]` sets event bit i at the next edge, and the bit stays set until a read or a clear. Bit meanings from 7 down to 0: power on, user request, command error, execution error, device error, query error, bus control request, operation complete.
- R3: Op code 0 returns the event register on `rd_data` in the next cycle and clears the register. A pulse that arrives in the same cycle as this read stays set after the clear.
- R4: `status_byte[5]` is 1 exactly when the event register ANDed with the event mask is non-zero.
- R5: `status_byte[4]` is 1 exactly when the queue holds at least one byte. Op code 7 pops bytes in the order `msg_push` wrote them.
- R6: The queue holds 16 bytes. A push to a full queue is dropped and sets event bit 2 (query error), unless a pop happens in the same cycle. A pop from an empty queue returns 0 and sets event bit 2.
- R7: Take the status byte with bit 6 forced to 0 and AND it with the service-request mask. When the result goes from zero to non-zero, `status_byte[6]` and `srq` go high at the following edge. Mask bit 6 has no effect.
- R8: Op code 5 (serial poll) returns the status byte, with the request flag as it stood before the poll, and then clears the request flag. `srq` then stays low while the masked condition remains non-zero.
- R9: Op code 6 (clear status) empties the event register, the queue and the request flag, and leaves both masks unchanged. A push in that same cycle is discarded. A pulse in that same cycle is kept.
- R10: Op codes 1 and 3 write the event mask and the service-request mask from `op_wdata`. Op codes 2 and 4 read them back. `rd_valid` is high for one cycle after op codes 0, 2, 4, 5 and 7.
- R11: Status bits 7 and 3..0 always read 0.
- R12: If a rising masked condition coincides with a serial poll or a clear status, the request flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | Single-cycle event pulses from the instrument core |
| msg_push | input | 1 | Push `msg_data` into the message queue |
| msg_data | input | 8 | Byte to queue |
| op_valid | input | 1 | Register operation present this cycle |
| op_code | input | 3 | Operation code (0 to 7, see requirements) |
| op_wdata | input | 8 | Write data for mask writes |
| rd_data | output | 8 | Read result, registered |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| status_byte | output | 8 | Current status byte |
| srq | output | 1 | Service request line |

## Verification
Two pairs of functions can fall in the same cycle. The first is an event pulse arriving together with a read-and-clear of the event register, where the new bit must survive. The second is a newly rising masked condition arriving together with a serial poll or clear status, where the request must win. The random phase applies pulses, queue pushes and register operations independently in every cycle, so both collisions happen often. Directed steps also force each collision once. A cycle-level bench model judges every outcome at the ports after the edge.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int SB_W       = 8;
  localparam int SB_ESB     = 5;
  localparam int SB_MAV     = 4;
  localparam int SB_RQS     = 6;
  localparam int EV_QUERY   = 2;

  typedef enum logic [2:0] {
    OP_EVT_READ  = 3'd0,
    OP_EMASK_WR  = 3'd1,
    OP_EMASK_RD  = 3'd2,
    OP_SMASK_WR  = 3'd3,
    OP_SMASK_RD  = 3'd4,
    OP_POLL      = 3'd5,
    OP_CLEAR     = 3'd6,
    OP_QUEUE_RD  = 3'd7
  } op_e;
endpackage

// File: rtl/sr_event_reg.sv
module sr_event_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_in,
  input  logic         clr,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] en_q,
  output logic         summary
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      en_q  <= '0;
    end else begin
      evt_q <= (clr ? '0 : evt_q) | set_in;
      if (en_wr) en_q <= en_wdata;
    end
  end

  assign summary = |(evt_q & en_q);

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));  // R2
  AST_CLR_KEEPS_PULSE: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((evt_q & $past(set_in)) == $past(set_in)));  // R3
endmodule

// File: rtl/sr_byte_fifo.sv
module sr_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic          full,
  output logic          ov_err,
  output logic          ud_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign pop_ok   = pop & ~empty & ~flush;
  assign push_ok  = push & ~flush & (~full | pop_ok);
  assign ov_err   = push & ~flush & ~push_ok;
  assign ud_err   = pop & empty;
  assign pop_data = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (!push_ok && pop_ok) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));  // R6
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (full && $stable(wptr)));  // R6
endmodule

// File: rtl/sr_service_req.sv
module sr_service_req #(
  parameter int W       = 8,
  parameter int RQS_POS = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sb_in,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  input  logic         poll,
  input  logic         clr,
  output logic [W-1:0] en_q,
  output logic         rqs_q
);
  localparam logic [W-1:0] RQS_MASK = ~({{(W-1){1'b0}}, 1'b1} << RQS_POS);

  logic cond, cond_q, rise;

  assign cond = |(sb_in & en_q & RQS_MASK);
  assign rise = cond & ~cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      cond_q <= 1'b0;
      rqs_q  <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      cond_q <= cond;
      if (rise)             rqs_q <= 1'b1;
      else if (poll || clr) rqs_q <= 1'b0;
    end
  end

  AST_RQS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rise |=> rqs_q);  // R7
  AST_POLL_CLEARS_RQS: assert property (@(posedge clk) disable iff (rst)
    (poll && !rise) |=> !rqs_q);  // R8
endmodule

// File: rtl/status_report_unit.sv
module status_report_unit
  import stat_pkg::*;
#(
  parameter int EVT_W  = 8,
  parameter int DW     = 8,
  parameter int QDEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic             msg_push,
  input  logic [DW-1:0]    msg_data,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [SB_W-1:0]  op_wdata,
  output logic [SB_W-1:0]  rd_data,
  output logic             rd_valid,
  output logic [SB_W-1:0]  status_byte,
  output logic             srq
);
  op_e             op;
  logic            do_evt_rd, do_clear, do_poll, do_pop;
  logic [EVT_W-1:0] evt_q, emask_q, evt_set;
  logic [SB_W-1:0]  smask_q, sb_sum;
  logic [DW-1:0]    q_out;
  logic             esb, q_empty, q_full, q_ov, q_ud, rqs_q;

  assign op        = op_e'(op_code);
  assign do_evt_rd = op_valid && (op == OP_EVT_READ);
  assign do_clear  = op_valid && (op == OP_CLEAR);
  assign do_poll   = op_valid && (op == OP_POLL);
  assign do_pop    = op_valid && (op == OP_QUEUE_RD);

  always_comb begin
    evt_set = evt_pulse;
    evt_set[EV_QUERY] = evt_pulse[EV_QUERY] | q_ov | q_ud;
  end

  sr_event_reg #(.W(EVT_W)) u_evt (
    .clk(clk), .rst(rst), .set_in(evt_set), .clr(do_evt_rd | do_clear),
    .en_wr(op_valid && (op == OP_EMASK_WR)), .en_wdata(op_wdata[EVT_W-1:0]),
    .evt_q(evt_q), .en_q(emask_q), .summary(esb)
  );

  sr_byte_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .flush(do_clear), .push(msg_push),
    .push_data(msg_data), .pop(do_pop), .pop_data(q_out),
    .empty(q_empty), .full(q_full), .ov_err(q_ov), .ud_err(q_ud)
  );

  always_comb begin
    sb_sum         = '0;
    sb_sum[SB_ESB] = esb;
    sb_sum[SB_MAV] = ~q_empty;
  end

  sr_service_req #(.W(SB_W), .RQS_POS(SB_RQS)) u_srq (
    .clk(clk), .rst(rst), .sb_in(sb_sum),
    .en_wr(op_valid && (op == OP_SMASK_WR)), .en_wdata(op_wdata),
    .poll(do_poll), .clr(do_clear), .en_q(smask_q), .rqs_q(rqs_q)
  );

  always_comb begin
    status_byte         = sb_sum;
    status_byte[SB_RQS] = rqs_q;
  end
  assign srq = rqs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (op_valid) begin
        case (op)
          OP_EVT_READ: begin rd_data <= SB_W'(evt_q);   rd_valid <= 1'b1; end
          OP_EMASK_RD: begin rd_data <= SB_W'(emask_q); rd_valid <= 1'b1; end
          OP_SMASK_RD: begin rd_data <= smask_q;        rd_valid <= 1'b1; end
          OP_POLL:     begin rd_data <= status_byte;    rd_valid <= 1'b1; end
          OP_QUEUE_RD: begin rd_data <= SB_W'(q_out);   rd_valid <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  AST_MAV_TRACKS_QUEUE: assert property (@(posedge clk) disable iff (rst)
    (q_full && !do_pop && !do_clear) |=> status_byte[SB_MAV]);  // R5
endmodule

// File: tb/status_report_unit_test.sv
module status_report_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_pulse = '0;
  logic       msg_push = 1'b0;
  logic [7:0] msg_data = '0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [7:0] op_wdata = '0;
  logic [7:0] rd_data, status_byte;
  logic       rd_valid, srq;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_evt = 0, m_emask = 0, m_smask = 0, m_rd = 0;
  logic       m_rqs = 0, m_condq = 0, m_rv = 0;
  logic [7:0] m_q[$];
  logic [2:0] last_op = 0;
  logic       last_opv = 0;

  always #5 clk = ~clk;

  status_report_unit uut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .msg_push(msg_push),
    .msg_data(msg_data), .op_valid(op_valid), .op_code(op_code),
    .op_wdata(op_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .status_byte(status_byte), .srq(srq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_sb();
    logic [7:0] s = '0;
    s[5] = |(m_evt & m_emask);
    s[4] = (m_q.size() != 0);
    s[6] = m_rqs;
    return s;
  endfunction

  // Advance the model by one edge using the inputs now driven.
  task automatic model_edge();
    logic [7:0] sb = model_sb();
    logic cond = |({sb[7], 1'b0, sb[5:0]} & m_smask);
    logic rise = cond & ~m_condq;
    logic qerr = 1'b0;
    logic cls = op_valid && op_code == 3'd6;
    logic [7:0] nevt = m_evt;
    m_rv = 1'b0;
    if (op_valid && op_code == 3'd7) begin
      m_rv = 1'b1;
      if (m_q.size() != 0) m_rd = m_q.pop_front();
      else begin m_rd = 8'h00; qerr = 1'b1; end
    end
    if (msg_push && !cls) begin
      if (m_q.size() < 16) m_q.push_back(msg_data);
      else qerr = 1'b1;
    end
    if (cls) m_q.delete();
    if (op_valid) begin
      case (op_code)
        3'd0: begin m_rd = m_evt; m_rv = 1'b1; nevt = '0; end
        3'd1: m_emask = op_wdata;
        3'd2: begin m_rd = m_emask; m_rv = 1'b1; end
        3'd3: m_smask = op_wdata;
        3'd4: begin m_rd = m_smask; m_rv = 1'b1; end
        3'd5: begin m_rd = sb; m_rv = 1'b1; end
        3'd6: nevt = '0;
        default: ;
      endcase
    end
    nevt = nevt | evt_pulse;
    nevt[2] = nevt[2] | qerr;
    m_evt = nevt;
    if (rise) m_rqs = 1'b1;
    else if (op_valid && (op_code == 3'd5 || op_code == 3'd6)) m_rqs = 1'b0;
    m_condq = cond;
  endtask

  task automatic step(input logic [7:0] pl, input logic push, input logic [7:0] pd,
                      input logic ov, input logic [2:0] oc, input logic [7:0] wd,
                      input string rtag);
    string t;
    logic [7:0] sb;
    evt_pulse = pl; msg_push = push; msg_data = pd;
    op_valid = ov; op_code = oc; op_wdata = wd;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    evt_pulse = '0; msg_push = 1'b0; op_valid = 1'b0;
    sb = model_sb();
    chk("R4 esb", {7'd0, status_byte[5]}, {7'd0, sb[5]});
    chk("R5 mav", {7'd0, status_byte[4]}, {7'd0, sb[4]});
    chk("R11 unused", status_byte & 8'h8F, 8'h00);
    t = (ov && (oc == 3'd5 || oc == 3'd6)) ? "R8 R9 R12 rqs" : "R7 rqs";
    chk(t, {6'd0, status_byte[6], srq}, {6'd0, m_rqs, m_rqs});
    chk("R10 rd_valid", {7'd0, rd_valid}, {7'd0, m_rv});
    if (m_rv) begin
      if (rtag.len() != 0) t = rtag;
      else case (oc)
        3'd0: t = "R3 evt read";
        3'd5: t = "R8 poll";
        3'd7: t = "R6 queue pop";
        default: t = "R10 mask read";
      endcase
      chk(t, rd_data, m_rd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset sb", status_byte, 8'h00);
    chk("R1 reset srq/rv", {6'd0, srq, rd_valid}, 8'h00);
    rst = 1'b0;
    step(0, 0, 0, 1, 3'd2, 0, "R1 emask after reset");
    step(0, 0, 0, 1, 3'd4, 0, "R1 smask after reset");
    // sticky event bit and bit order
    step(8'h80, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 1, 3'd0, 0, "R2 sticky power-on bit");
    // pulse collides with read-and-clear
    step(8'h01, 0, 0, 0, 0, 0, "");
    step(8'h10, 0, 0, 1, 3'd0, 0, "R3 read during pulse");
    step(0, 0, 0, 1, 3'd0, 0, "R3 pulse survived clear");
    // masks and service request
    step(0, 0, 0, 1, 3'd1, 8'h10, "");
    step(0, 0, 0, 1, 3'd3, 8'h60, "");
    step(8'h10, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 1, 3'd5, 0, "R8 poll with rqs");
    step(0, 0, 0, 0, 0, 0, "");
    // fill and overflow queue
    for (int i = 0; i < 17; i++) step(0, 1, 8'(i + 8'h30), 0, 0, 0, "");
    step(0, 1, 8'hEE, 1, 3'd7, 0, "R6 pop while full with push");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 3'd7, 0, "R5 fifo order");
    step(0, 0, 0, 1, 3'd7, 0, "R6 pop empty");
    step(0, 0, 0, 1, 3'd0, 0, "R6 query error bit");
    // rising condition meets poll
    step(0, 0, 0, 1, 3'd3, 8'h10, "");
    step(0, 1, 8'h55, 1, 3'd5, 0, "R12 poll");
    step(0, 0, 0, 1, 3'd5, 0, "R12 poll");
    // clear status keeps masks, drops same-cycle push, keeps pulse
    step(8'h04, 1, 8'h77, 1, 3'd6, 0, "");
    step(0, 0, 0, 1, 3'd2, 0, "R9 emask kept");
    step(0, 0, 0, 1, 3'd4, 0, "R9 smask kept");
    step(0, 0, 0, 1, 3'd0, 0, "R9 pulse kept on clear");
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] pl = (($urandom % 6) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      logic ps = (($urandom % 3) != 0);
      logic ov = (($urandom % 3) == 0);
      logic [2:0] oc = 3'($urandom % 8);
      if (oc == 3'd6 && ($urandom % 4) != 0) oc = 3'd7;
      step(pl, ps, 8'($urandom), ov, oc, 8'($urandom), "");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule